// File: doc/BRIEF.md
# Impulse Noise Blanker Trigger

This block watches a stream of digitised multiplex samples that have already been high-pass filtered and rectified, and it spots the short, tall spikes that ignition and motor interference put into a broadcast signal. When a sample stands out far enough above the recent signal envelope, the block drives an active-low hold strobe. That strobe freezes the downstream audio sample-and-hold for a programmed time, so the spike never reaches the loudspeakers.

The block keeps a smoothed envelope of the rectified samples. It rises fast and falls slowly. The trigger level is that envelope plus a threshold. The threshold starts from a programmable floor and climbs as the envelope grows with noise. Two more settings can lift the envelope used for the comparison: one follows the measured modulation deviation, the other follows the reception quality. Every trigger reloads a retriggerable timer with one of four hold times. Sample values and voltage-like settings use one LSB per millivolt-equivalent.

Top module: `spike_blanker`

## Requirements
- R1: While reset is low, `hold_n` is 1 and `peak_out` is 0.
- R2: On a cycle with `smp_vld`=1 the envelope p updates. If the sample s is at least p, p becomes p + ((s-p) >> 2). Otherwise p becomes p - ((p-s) >> 5). Without `smp_vld` the envelope holds. `peak_out` shows p.
- R3: When the effective envelope e is at most 900, the threshold is 65 - 5*`cfg_lo_thr`. Code 0 gives 65 and code 7 gives 30.
- R4: When e is at least 1500, the threshold is 260 - 40*`cfg_noise_slope` (code 0 gives 260, code 3 gives 140). For 900 < e < 1500 it is lo + floor((e-900)*(hi-lo)*109 / 65536), where lo is the R3 value and hi is the R4 value.
- R5: The deviation term is min(`dev_mag`, cap). The cap is 2800, 2000 or 1200 for `cfg_dev_sel` 0, 1 or 2. Code 3 forces the term to 0. e is the largest of p, the deviation term and the R6 floor.
- R6: When `fs_level` is below 8 and `cfg_fs_sel` is not 3, a floor of 2300, 1800 or 1300 applies for codes 0, 1 or 2. Otherwise the floor is 0.
- R7: A trigger happens on a clock edge with `cfg_en`=1, `smp_vld`=1 and s strictly greater than e + threshold. Here e uses the envelope from before this sample's update.
- R8: After a trigger, `hold_n` is 0 for exactly N cycles and then returns to 1. N is floor(CLK_KHZ*t/10^6), where t is 38000, 25500, 32000 or 22000 ns for `cfg_hold_sel` 0 to 3. At the default CLK_KHZ=1000 this gives 38, 25, 32 and 22.
- R9: A trigger during a hold reloads N from that edge. This includes a trigger on the last cycle of the hold.
- R10: On any edge with `cfg_en`=0, the hold is cancelled and `hold_n` is 1 in the following cycle, even if a spike arrives on that edge. No trigger takes place while the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | A new rectified sample is present |
| smp_rect | input | DW | Rectified, high-passed sample |
| dev_mag | input | DW | Measured deviation magnitude |
| fs_level | input | FSW | Field-strength code (low = weak) |
| cfg_en | input | 1 | Blanker enable |
| cfg_lo_thr | input | 3 | Base threshold code |
| cfg_noise_slope | input | 2 | Noise-controlled threshold code |
| cfg_dev_sel | input | 2 | Deviation cap select, 3 = off |
| cfg_fs_sel | input | 2 | Weak-signal floor select, 3 = off |
| cfg_hold_sel | input | 2 | Hold time select |
| hold_n | output | 1 | Active-low hold strobe, registered |
| peak_out | output | DW | Smoothed envelope |

## Verification
Two of the block's functions can meet on one clock edge:
- A fresh trigger can land on the very edge where a running hold would lapse. The bench provokes this by placing a second spike exactly N cycles after the first. The reload must win, so the low time is exactly 2N.
- A disable can arrive together with a spike that would otherwise fire. The bench drives both on the same edge. The disable must win and leave the strobe high.

The bench also mixes these coincidences into randomised traffic. There, a behavioural model computes the envelope and strobe on every clock edge, and both outputs are compared with it each cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;

   localparam int unsigned KNEE_LO = 900;
   localparam int unsigned KNEE_HI = 1500;
   localparam int unsigned SLOPE_K = 109;   // 65536 / (KNEE_HI - KNEE_LO)
   localparam int unsigned SLOPE_SH = 16;

   typedef struct packed {
      logic [2:0] lo_code;
      logic [1:0] slope_code;
      logic [1:0] dev_code;
      logic [1:0] fs_code;
   } thr_cfg_t;

   function automatic int unsigned base_thr(input logic [2:0] code);
      return 32'd65 - 32'd5 * 32'(code);
   endfunction

   function automatic int unsigned noise_thr(input logic [1:0] code);
      return 32'd260 - 32'd40 * 32'(code);
   endfunction

   function automatic int unsigned dev_cap(input logic [1:0] code);
      case (code)
         2'd0:    return 32'd2800;
         2'd1:    return 32'd2000;
         2'd2:    return 32'd1200;
         default: return 32'd0;
      endcase
   endfunction

   function automatic int unsigned fs_floor(input logic [1:0] code);
      case (code)
         2'd0:    return 32'd2300;
         2'd1:    return 32'd1800;
         2'd2:    return 32'd1300;
         default: return 32'd0;
      endcase
   endfunction

endpackage

// File: rtl/sb_peak_track.sv
module sb_peak_track #(
   parameter int DW     = 12,
   parameter int ATK_SH = 2,
   parameter int DEC_SH = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_vld,
   input  logic [DW-1:0] smp,
   output logic [DW-1:0] peak
);
   logic [DW-1:0] rise_v;
   logic [DW-1:0] fall_v;

   generate
      if (DEC_SH <= ATK_SH) begin : g_bad_shift
         $error("decay shift must exceed attack shift");
      end
      if (ATK_SH == 0) begin : g_inst_atk
         assign rise_v = smp;
      end else begin : g_shift_atk
         assign rise_v = peak + ((smp - peak) >> ATK_SH);
      end
   endgenerate

   assign fall_v = peak - ((peak - smp) >> DEC_SH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       peak <= '0;
      else if (smp_vld) peak <= (smp >= peak) ? rise_v : fall_v;
   end

   a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(peak));
   a_r2_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && smp >= peak) |=> (peak <= $past(smp) && peak >= $past(peak)));
   a_r2_no_undershoot: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && smp < peak) |=> (peak >= $past(smp) && peak <= $past(peak)));
endmodule

// File: rtl/sb_thresh_gen.sv
module sb_thresh_gen
   import sb_pkg::*;
#(
   parameter int          DW      = 12,
   parameter int          FSW     = 4,
   parameter int          TW      = 9,
   parameter int unsigned FS_WEAK = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [DW-1:0]  peak,
   input  logic [DW-1:0]  dev_mag,
   input  logic [FSW-1:0] fs_level,
   input  thr_cfg_t       cfg,
   output logic [DW-1:0]  eff_peak,
   output logic [TW-1:0]  thr
);
   int unsigned dterm, fterm, eff_i, lo_i, hi_i, thr_i;

   always_comb begin
      dterm = 0;
      if (cfg.dev_code != 2'b11)
         dterm = (32'(dev_mag) > dev_cap(cfg.dev_code)) ? dev_cap(cfg.dev_code) : 32'(dev_mag);
      fterm = 0;
      if (cfg.fs_code != 2'b11 && 32'(fs_level) < FS_WEAK)
         fterm = fs_floor(cfg.fs_code);
      eff_i = 32'(peak);
      if (dterm > eff_i) eff_i = dterm;
      if (fterm > eff_i) eff_i = fterm;
      lo_i = base_thr(cfg.lo_code);
      hi_i = noise_thr(cfg.slope_code);
      if (eff_i <= KNEE_LO)      thr_i = lo_i;
      else if (eff_i >= KNEE_HI) thr_i = hi_i;
      else thr_i = lo_i + (((eff_i - KNEE_LO) * (hi_i - lo_i) * SLOPE_K) >> SLOPE_SH);
   end

   assign eff_peak = DW'(eff_i);
   assign thr      = TW'(thr_i);

   a_r4_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(thr) >= base_thr(cfg.lo_code)) && (32'(thr) <= noise_thr(cfg.slope_code)));
   a_r5_eff_covers_peak: assert property (@(posedge clk) disable iff (!rst_n)
      eff_peak >= peak);
endmodule

// File: rtl/sb_hold_timer.sv
module sb_hold_timer #(
   parameter int unsigned CLK_KHZ = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       trig,
   input  logic [1:0] sel,
   output logic       hold_n
);
   localparam int unsigned NS_TAB [4] = '{38000, 25500, 32000, 22000};
   localparam int unsigned MAX_LEN = int'(longint'(CLK_KHZ) * 38000 / 1000000);
   localparam int CW = $clog2(MAX_LEN + 1);

   logic [CW-1:0] len_tab [4];
   logic [CW-1:0] cnt;

   generate
      for (genvar i = 0; i < 4; i++) begin : g_len
         localparam int unsigned L = int'(longint'(CLK_KHZ) * NS_TAB[i] / 1000000);
         if (L < 1) begin : g_bad_len
            $error("clock too slow for hold time");
         end
         assign len_tab[i] = CW'(L);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         hold_n <= 1'b1;
      end else if (!en) begin
         cnt    <= '0;
         hold_n <= 1'b1;
      end else if (trig) begin
         cnt    <= len_tab[sel];
         hold_n <= 1'b0;
      end else if (cnt > CW'(1)) begin
         cnt    <= cnt - CW'(1);
      end else if (cnt == CW'(1)) begin
         cnt    <= '0;
         hold_n <= 1'b1;
      end
   end

   a_r10_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> hold_n);
   a_r9_trig_low: assert property (@(posedge clk) disable iff (!rst_n)
      (en && trig) |=> !hold_n);
   a_r8_count_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> !hold_n);
   a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !trig && cnt == CW'(1)) |=> hold_n);
endmodule

// File: rtl/spike_blanker.sv
module spike_blanker
   import sb_pkg::*;
#(
   parameter int          DW      = 12,
   parameter int          FSW     = 4,
   parameter int unsigned FS_WEAK = 8,
   parameter int          ATK_SH  = 2,
   parameter int          DEC_SH  = 5,
   parameter int unsigned CLK_KHZ = 1000
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           smp_vld,
   input  logic [DW-1:0]  smp_rect,
   input  logic [DW-1:0]  dev_mag,
   input  logic [FSW-1:0] fs_level,
   input  logic           cfg_en,
   input  logic [2:0]     cfg_lo_thr,
   input  logic [1:0]     cfg_noise_slope,
   input  logic [1:0]     cfg_dev_sel,
   input  logic [1:0]     cfg_fs_sel,
   input  logic [1:0]     cfg_hold_sel,
   output logic           hold_n,
   output logic [DW-1:0]  peak_out
);
   localparam int TW = 9;

   generate
      if (DW < 12) begin : g_bad_dw
         $error("DW must hold 4095 mV-equivalent");
      end
      if (FS_WEAK > (1 << FSW)) begin : g_bad_fs
         $error("FS_WEAK exceeds field-strength range");
      end
   endgenerate

   thr_cfg_t      cfg;
   logic [DW-1:0] eff_peak;
   logic [TW-1:0] thr;
   logic          trig;

   assign cfg = '{lo_code: cfg_lo_thr, slope_code: cfg_noise_slope,
                  dev_code: cfg_dev_sel, fs_code: cfg_fs_sel};

   sb_peak_track #(.DW(DW), .ATK_SH(ATK_SH), .DEC_SH(DEC_SH)) u_peak (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp_rect), .peak(peak_out));

   sb_thresh_gen #(.DW(DW), .FSW(FSW), .TW(TW), .FS_WEAK(FS_WEAK)) u_thr (
      .clk(clk), .rst_n(rst_n), .peak(peak_out), .dev_mag(dev_mag), .fs_level(fs_level),
      .cfg(cfg), .eff_peak(eff_peak), .thr(thr));

   assign trig = cfg_en && smp_vld &&
                 ({1'b0, smp_rect} > ({1'b0, eff_peak} + (DW+1)'(thr)));

   sb_hold_timer #(.CLK_KHZ(CLK_KHZ)) u_hold (
      .clk(clk), .rst_n(rst_n), .en(cfg_en), .trig(trig), .sel(cfg_hold_sel), .hold_n(hold_n));

   a_r7_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_n && !smp_vld) |=> hold_n);
   a_r7_small_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_n && smp_rect <= peak_out) |=> hold_n);
endmodule

// File: tb/spike_blanker_test.sv
module spike_blanker_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_vld = 1'b0;
   logic [11:0] smp_rect = '0;
   logic [11:0] dev_mag = '0;
   logic [3:0]  fs_level = 4'd15;
   logic        cfg_en = 1'b0;
   logic [2:0]  cfg_lo_thr = '0;
   logic [1:0]  cfg_noise_slope = '0;
   logic [1:0]  cfg_dev_sel = 2'd3;
   logic [1:0]  cfg_fs_sel = 2'd3;
   logic [1:0]  cfg_hold_sel = '0;
   logic        hold_n;
   logic [11:0] peak_out;

   int    n_run = 0;
   int    n_fail = 0;
   bit    chk_on = 0;
   string cur_req = "R2";

   int m_peak = 0, m_cnt = 0, m_hold = 1;

   spike_blanker uut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_rect(smp_rect), .dev_mag(dev_mag),
      .fs_level(fs_level), .cfg_en(cfg_en), .cfg_lo_thr(cfg_lo_thr),
      .cfg_noise_slope(cfg_noise_slope), .cfg_dev_sel(cfg_dev_sel), .cfg_fs_sel(cfg_fs_sel),
      .cfg_hold_sel(cfg_hold_sel), .hold_n(hold_n), .peak_out(peak_out));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference model, straight from the requirements
   function automatic int m_eff(int pk, int dv, int fsl, int ovd, int fsc);
      int caps[4]  = '{2800, 2000, 1200, 0};
      int flrs[4]  = '{2300, 1800, 1300, 0};
      int e = pk;
      if (ovd != 3 && ((dv < caps[ovd]) ? dv : caps[ovd]) > e) e = (dv < caps[ovd]) ? dv : caps[ovd];
      if (fsc != 3 && fsl < 8 && flrs[fsc] > e) e = flrs[fsc];
      return e;
   endfunction

   function automatic int m_thr(int e, int lc, int nc);
      int lo = 65 - 5*lc;
      int hi = 260 - 40*nc;
      if (e <= 900)  return lo;
      if (e >= 1500) return hi;
      return lo + ((e - 900) * (hi - lo) * 109) / 65536;
   endfunction

   function automatic int m_len(int sel);
      int lens[4] = '{38, 25, 32, 22};
      return lens[sel];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_peak = 0; m_cnt = 0; m_hold = 1;
      end else begin
         int e, th;
         bit fire;
         e  = m_eff(m_peak, int'(dev_mag), int'(fs_level), int'(cfg_dev_sel), int'(cfg_fs_sel));
         th = m_thr(e, int'(cfg_lo_thr), int'(cfg_noise_slope));
         fire = cfg_en && smp_vld && (int'(smp_rect) > e + th);
         if (!cfg_en) begin m_cnt = 0; m_hold = 1; end
         else if (fire) begin m_cnt = m_len(int'(cfg_hold_sel)); m_hold = 0; end
         else if (m_cnt > 1) m_cnt--;
         else if (m_cnt == 1) begin m_cnt = 0; m_hold = 1; end
         if (smp_vld) begin
            if (int'(smp_rect) >= m_peak) m_peak += (int'(smp_rect) - m_peak) >> 2;
            else                          m_peak -= (m_peak - int'(smp_rect)) >> 5;
         end
      end
   end

   always @(negedge clk) begin
      if (chk_on) begin
         chk(int'(hold_n) == m_hold, {cur_req, " strobe vs model"}, int'(hold_n), m_hold);
         chk(int'(peak_out) == m_peak, "R2 envelope vs model", int'(peak_out), m_peak);
      end
   end

   task automatic quiet(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         smp_vld = 1'b1; smp_rect = 12'd100;
      end
   endtask

   task automatic spike_once(input int v);
      @(negedge clk);
      smp_vld = 1'b1; smp_rect = 12'(v);
      @(negedge clk);
      smp_vld = 1'b1; smp_rect = 12'd100;
   endtask

   // Fire a spike, optionally a second at offset k, count low cycles
   task automatic measure(input int k, output int lows);
      lows = 0;
      @(negedge clk);
      smp_vld = 1'b1; smp_rect = 12'd3000;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (!hold_n) lows++;
         smp_rect = (k > 0 && i == k-1) ? 12'd3000 : 12'd100;
      end
   endtask

   initial begin
      int lows;
      #(CLK_PERIOD * WATCHDOG);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int lows, pk;
      repeat (3) @(negedge clk);
      chk(hold_n == 1'b1, "R1 strobe in reset", int'(hold_n), 1);
      chk(peak_out == 12'd0, "R1 envelope in reset", int'(peak_out), 0);
      rst_n = 1'b1;
      cfg_en = 1'b1;
      chk_on = 1;

      cur_req = "R2";
      quiet(300);

      // R3: base threshold boundary, code 0 (65) then code 7 (30)
      cur_req = "R3";
      pk = m_peak;
      spike_once(pk + 65);
      chk(hold_n == 1'b1, "R3 at peak+65 code0", int'(hold_n), 1);
      quiet(300);
      pk = m_peak;
      spike_once(pk + 66);
      chk(hold_n == 1'b0, "R3 at peak+66 code0", int'(hold_n), 0);
      quiet(300);
      cfg_lo_thr = 3'd7;
      pk = m_peak;
      spike_once(pk + 30);
      chk(hold_n == 1'b1, "R3 at peak+30 code7", int'(hold_n), 1);
      quiet(300);
      pk = m_peak;
      spike_once(pk + 31);
      chk(hold_n == 1'b0, "R3 at peak+31 code7", int'(hold_n), 0);
      quiet(300);

      // R8: hold length per code
      cur_req = "R8";
      for (int s = 0; s < 4; s++) begin
         int exp_l[4] = '{38, 25, 32, 22};
         cfg_hold_sel = 2'(s);
         measure(0, lows);
         chk(lows == exp_l[s], "R8 hold length", lows, exp_l[s]);
         quiet(300);
      end

      // R9: retrigger mid-hold and exactly on the last hold cycle
      cur_req = "R9";
      cfg_hold_sel = 2'd0;
      measure(10, lows);
      chk(lows == 48, "R9 retrigger at +10", lows, 48);
      quiet(300);
      measure(38, lows);
      chk(lows == 76, "R9 retrigger on last cycle", lows, 76);
      quiet(300);

      // R10: disable mid-hold, and disable together with a spike
      cur_req = "R10";
      @(negedge clk); smp_rect = 12'd3000;
      repeat (5) @(negedge clk) smp_rect = 12'd100;
      cfg_en = 1'b0;
      @(negedge clk);
      chk(hold_n == 1'b1, "R10 disable mid-hold", int'(hold_n), 1);
      smp_rect = 12'd3000;
      @(negedge clk);
      chk(hold_n == 1'b1, "R10 spike while disabled", int'(hold_n), 1);
      smp_rect = 12'd100;
      quiet(300);
      @(negedge clk); cfg_en = 1'b1; smp_rect = 12'd3000;
      @(negedge clk); cfg_en = 1'b0; smp_rect = 12'd3000;
      @(negedge clk);
      chk(hold_n == 1'b1, "R10 disable with spike same edge", int'(hold_n), 1);
      cfg_en = 1'b1; smp_rect = 12'd100;
      quiet(300);

      // R5: deviation term lifts envelope
      cur_req = "R5";
      cfg_lo_thr = 3'd0;
      dev_mag = 12'd2500; cfg_dev_sel = 2'd1;
      spike_once(1000);
      chk(hold_n == 1'b1, "R5 dev cap 2000 blocks 1000", int'(hold_n), 1);
      quiet(50);
      spike_once(2261);
      chk(hold_n == 1'b0, "R5 2261 over 2000+260", int'(hold_n), 0);
      quiet(300);
      cfg_dev_sel = 2'd3;
      spike_once(1000);
      chk(hold_n == 1'b0, "R5 detector off", int'(hold_n), 0);
      quiet(300);

      // R6: weak-reception floor
      cur_req = "R6";
      fs_level = 4'd3; cfg_fs_sel = 2'd2;
      spike_once(1000);
      chk(hold_n == 1'b1, "R6 floor 1300 blocks 1000", int'(hold_n), 1);
      quiet(50);
      fs_level = 4'd12;
      spike_once(1000);
      chk(hold_n == 1'b0, "R6 strong signal no floor", int'(hold_n), 0);
      quiet(300);
      fs_level = 4'd3; cfg_fs_sel = 2'd3;
      spike_once(1000);
      chk(hold_n == 1'b0, "R6 floor switched off", int'(hold_n), 0);
      quiet(300);
      fs_level = 4'd15;

      // R4: noise region, envelope between and above the knees
      cur_req = "R4";
      for (int b = 0; b < 2; b++) begin
         for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (i % 200 == 0) cfg_noise_slope = 2'($urandom_range(0, 3));
            smp_rect = 12'(((b == 0) ? 1200 : 1700) + $urandom_range(0, 40));
            if ($urandom_range(0, 30) == 0) smp_rect = 12'($urandom_range(1250, 2100));
         end
      end

      // R7: mixed random traffic
      cur_req = "R7";
      for (int i = 0; i < 6000; i++) begin
         @(negedge clk);
         if (i % 150 == 0) begin
            cfg_lo_thr = 3'($urandom_range(0, 7));
            cfg_noise_slope = 2'($urandom_range(0, 3));
            cfg_dev_sel = 2'($urandom_range(0, 3));
            cfg_fs_sel = 2'($urandom_range(0, 3));
            cfg_hold_sel = 2'($urandom_range(0, 3));
            dev_mag = 12'($urandom_range(0, 3200));
            fs_level = 4'($urandom_range(0, 15));
         end
         cfg_en = ($urandom_range(0, 99) != 0);
         smp_vld = ($urandom_range(0, 7) != 0);
         smp_rect = 12'($urandom_range(0, 1800));
         if ($urandom_range(0, 20) == 0) smp_rect = 12'($urandom_range(1800, 4095));
      end

      chk_on = 0;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule